// File: doc/BRIEF.md
# Double-Buffered Four-Channel Converter Code Bank

This block keeps the digital codes for a four-channel, 12-bit digital-to-analog converter. Every channel has two stages. The first is a staging register that a write fills. The second is an active register that drives the converter. A parallel write port takes the place of the serial bus engine. One strobe marks a finished, valid write and carries three things: a channel number, a 16-bit word and a hold bit.

While hold is high, writes only change the staging registers, and the active outputs stay frozen. A write with hold low is a load event. At that event, each channel whose staging register was written since its last transfer copies that register into its active register. All such channels do this on the same clock edge. Channels with no new data are left alone, so a load event never disturbs an output that has nothing new to show.

The 16-bit word has three fields. The top two bits choose a power-down mode. The next twelve bits are the code. The two lowest bits are ignored. The block decodes the active mode of each channel into one-hot drive flags. It also returns any channel's staging register in the same word layout, with the ignored bits read as zero.

Top module: `dac_reg_bank`

## Requirements
- R1: After reset, every active code is 0, every channel reports mode 00 (the normal-operation flag is set), and readback of every channel returns 0.
- R2: A write with load_hold high updates only the addressed channel's staging register, as seen in readback. Every active code and mode stays unchanged.
- R3: A write with load_hold low is a load event. From the next clock edge, the addressed channel's active register holds the word just written, not its earlier staged contents.
- R4: If three channels are written with load_hold high and the fourth is then written with load_hold low, all four active registers take their staged values on the same clock edge.
- R5: At a load event, a channel whose staging register has not been written since its last transfer keeps its active code and mode unchanged.
- R6: While wr_en is low, the values on wr_ch, wr_data and load_hold have no effect on any staging or active register.
- R7: wr_data[15:14] selects the mode. 00 means normal operation (out_on). 01 means a low-resistance pull to ground (out_load_lo). 10 means a high-resistance pull to ground (out_load_hi). 11 means a high-impedance output (out_float). Exactly one flag is set per channel.
- R8: A new mode is staged along with its code. It reaches dac_pd and the drive flags only when that channel's transfer happens.
- R9: rd_data returns the staging register of channel rd_ch in this layout: mode in bits 15:14, code in bits 13:2, and bits 1:0 always zero, whatever was written there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Strobe marking a completed valid write |
| wr_ch | input | 2 | Channel addressed by the write |
| wr_data | input | 16 | Written word: mode 15:14, code 13:2, 1:0 ignored |
| load_hold | input | 1 | High keeps the active registers; low makes the write a load event |
| rd_ch | input | 2 | Channel selected for readback |
| rd_data | output | 16 | Staged word of channel rd_ch, ignored bits zero |
| dac_code | output | 48 | Active 12-bit codes, channel c at bits 12c+11:12c |
| dac_pd | output | 8 | Active 2-bit modes, channel c at bits 2c+1:2c |
| out_on | output | 4 | Per-channel normal-operation flag |
| out_load_lo | output | 4 | Per-channel low-resistance pull-down flag |
| out_load_hi | output | 4 | Per-channel high-resistance pull-down flag |
| out_float | output | 4 | Per-channel high-impedance flag |

## Verification
The bench builds the block with its default parameters: four channels, 12-bit codes and a 16-bit word. At this size, every channel can be swept through all four power-down modes with codes at both extremes and at scattered values in between, and each write is followed by a check of all channels' active outputs and readback. The two-bit channel select also makes the full load-all-four case and every mix of stale and pending channels reachable in a few cycles.

// File: rtl/dac_bank_pkg.sv
package dac_bank_pkg;

  localparam int PD_W = 2;

  typedef enum logic [PD_W-1:0] {
    PD_ACTIVE  = 2'b00,
    PD_PULL_LO = 2'b01,
    PD_PULL_HI = 2'b10,
    PD_FLOAT   = 2'b11
  } pd_mode_e;

endpackage

// File: rtl/dac_chan_slice.sv
module dac_chan_slice #(
  parameter int ENTRY_W = 14
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_sel,
  input  logic [ENTRY_W-1:0] wr_entry,
  input  logic               xfer,
  output logic [ENTRY_W-1:0] in_entry,
  output logic [ENTRY_W-1:0] out_entry
);

  logic [ENTRY_W-1:0] in_q, in_d, out_q, out_d;
  logic               pend_q, pend_d;
  logic               pend_eff, do_xfer;
  logic               in_en, out_en, pend_en;

  always_comb begin
    pend_eff = pend_q | wr_sel;
    do_xfer  = xfer & pend_eff;
    in_en    = wr_sel;
    in_d     = wr_entry;
    out_en   = do_xfer;
    out_d    = wr_sel ? wr_entry : in_q;
    pend_en  = wr_sel | do_xfer;
    pend_d   = ~do_xfer;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q   <= '0;
      out_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (in_en)   in_q   <= in_d;
      if (out_en)  out_q  <= out_d;
      if (pend_en) pend_q <= pend_d;
    end
  end

  assign in_entry  = in_q;
  assign out_entry = out_q;

  assert_out_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer |=> $stable(out_q));

  assert_fresh_data_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && wr_sel) |=> (out_q == $past(wr_entry)));

  assert_pend_cleared_R3: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> !pend_q);

  assert_stale_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !wr_sel && !pend_q) |=> $stable(out_q));

  assert_stage_kept_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_sel |=> $stable(in_q));

endmodule

// File: rtl/dac_pd_decode.sv
module dac_pd_decode
  import dac_bank_pkg::*;
#(
  parameter int NUM_CH = 4
) (
  input  logic [NUM_CH*PD_W-1:0] pd_flat,
  output logic [NUM_CH-1:0]      on,
  output logic [NUM_CH-1:0]      load_lo,
  output logic [NUM_CH-1:0]      load_hi,
  output logic [NUM_CH-1:0]      floating
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pd_mode_e mode;
    assign mode = pd_mode_e'(pd_flat[c*PD_W +: PD_W]);
    always_comb begin
      on[c]       = 1'b0;
      load_lo[c]  = 1'b0;
      load_hi[c]  = 1'b0;
      floating[c] = 1'b0;
      case (mode)
        PD_ACTIVE:  on[c]       = 1'b1;
        PD_PULL_LO: load_lo[c]  = 1'b1;
        PD_PULL_HI: load_hi[c]  = 1'b1;
        default:    floating[c] = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/dac_readback.sv
module dac_readback #(
  parameter int NUM_CH  = 4,
  parameter int ENTRY_W = 14,
  parameter int WORD_W  = 16,
  parameter int SEL_W   = 2
) (
  input  logic [NUM_CH*ENTRY_W-1:0] entries,
  input  logic [SEL_W-1:0]          rd_ch,
  output logic [WORD_W-1:0]         rd_data
);

  localparam int PAD = WORD_W - ENTRY_W;

  logic [ENTRY_W-1:0] picked;

  always_comb begin
    picked = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (int'(rd_ch) == c) picked = entries[c*ENTRY_W +: ENTRY_W];
    end
    rd_data = WORD_W'(picked) << PAD;
  end

endmodule

// File: rtl/dac_reg_bank.sv
module dac_reg_bank
  import dac_bank_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int CODE_W = 12,
  parameter int WORD_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [$clog2(NUM_CH)-1:0] wr_ch,
  input  logic [WORD_W-1:0]        wr_data,
  input  logic                     load_hold,
  input  logic [$clog2(NUM_CH)-1:0] rd_ch,
  output logic [WORD_W-1:0]        rd_data,
  output logic [NUM_CH*CODE_W-1:0] dac_code,
  output logic [NUM_CH*PD_W-1:0]   dac_pd,
  output logic [NUM_CH-1:0]        out_on,
  output logic [NUM_CH-1:0]        out_load_lo,
  output logic [NUM_CH-1:0]        out_load_hi,
  output logic [NUM_CH-1:0]        out_float
);

  localparam int SEL_W   = $clog2(NUM_CH);
  localparam int ENTRY_W = PD_W + CODE_W;

  logic [ENTRY_W-1:0]        wr_entry;
  logic                      xfer;
  logic [NUM_CH-1:0]         wr_sel;
  logic [NUM_CH*ENTRY_W-1:0] in_flat;
  logic [NUM_CH*ENTRY_W-1:0] out_flat;

  assign wr_entry = wr_data[WORD_W-1 -: ENTRY_W];
  assign xfer     = wr_en & ~load_hold;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_slice
    assign wr_sel[c] = wr_en && (int'(wr_ch) == c);

    dac_chan_slice #(.ENTRY_W(ENTRY_W)) u_slice (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_sel    (wr_sel[c]),
      .wr_entry  (wr_entry),
      .xfer      (xfer),
      .in_entry  (in_flat[c*ENTRY_W +: ENTRY_W]),
      .out_entry (out_flat[c*ENTRY_W +: ENTRY_W])
    );

    assign dac_code[c*CODE_W +: CODE_W] = out_flat[c*ENTRY_W +: CODE_W];
    assign dac_pd[c*PD_W +: PD_W]       = out_flat[c*ENTRY_W + CODE_W +: PD_W];

    assert_one_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot({out_on[c], out_load_lo[c], out_load_hi[c], out_float[c]}));

    assert_float_code_R7: assert property (@(posedge clk) disable iff (!rst_n)
      out_float[c] == (dac_pd[c*PD_W +: PD_W] == 2'b11));
  end

  dac_pd_decode #(.NUM_CH(NUM_CH)) u_decode (
    .pd_flat  (dac_pd),
    .on       (out_on),
    .load_lo  (out_load_lo),
    .load_hi  (out_load_hi),
    .floating (out_float)
  );

  dac_readback #(
    .NUM_CH  (NUM_CH),
    .ENTRY_W (ENTRY_W),
    .WORD_W  (WORD_W),
    .SEL_W   (SEL_W)
  ) u_readback (
    .entries (in_flat),
    .rd_ch   (rd_ch),
    .rd_data (rd_data)
  );

  assert_pad_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[WORD_W-ENTRY_W-1:0] == '0);

endmodule

// File: tb/tb_dac_reg_bank.sv
module tb_dac_reg_bank;

  localparam int CLK_PERIOD = 10;
  localparam int NCH = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_ch;
  logic [15:0] wr_data;
  logic        load_hold;
  logic [1:0]  rd_ch;
  logic [15:0] rd_data;
  logic [47:0] dac_code;
  logic [7:0]  dac_pd;
  logic [3:0]  out_on, out_load_lo, out_load_hi, out_float;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [13:0] m_in  [NCH];
  logic [13:0] m_out [NCH];
  bit          m_pend[NCH];

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_reg_bank dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_ch(wr_ch),
    .wr_data(wr_data), .load_hold(load_hold), .rd_ch(rd_ch),
    .rd_data(rd_data), .dac_code(dac_code), .dac_pd(dac_pd),
    .out_on(out_on), .out_load_lo(out_load_lo),
    .out_load_hi(out_load_hi), .out_float(out_float)
  );

  task automatic check(string tag, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic check_all(string tag);
    for (int c = 0; c < NCH; c++) begin
      logic [3:0] exp_flags;
      exp_flags = 4'b0001 << m_out[c][13:12];
      check(tag, $sformatf("code ch%0d", c), 32'(dac_code[c*12 +: 12]), 32'(m_out[c][11:0]));
      check(tag, $sformatf("mode ch%0d", c), 32'(dac_pd[c*2 +: 2]), 32'(m_out[c][13:12]));
      check("R7", $sformatf("flags ch%0d", c),
            32'({out_float[c], out_load_hi[c], out_load_lo[c], out_on[c]}), 32'(exp_flags));
      rd_ch = 2'(c);
      #1;
      check("R9", $sformatf("readback ch%0d", c), 32'(rd_data), 32'({m_in[c], 2'b00}));
    end
  endtask

  task automatic wr(int ch, logic [15:0] w, logic h, string tag);
    @(negedge clk);
    wr_en = 1'b1; wr_ch = 2'(ch); wr_data = w; load_hold = h;
    @(posedge clk);
    m_in[ch] = w[15:2];
    m_pend[ch] = 1'b1;
    if (!h) begin
      for (int c = 0; c < NCH; c++) begin
        if (m_pend[c]) begin
          m_out[c] = m_in[c];
          m_pend[c] = 1'b0;
        end
      end
    end
    @(negedge clk);
    wr_en = 1'b0;
    check_all(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_ch = '0; wr_data = '0; load_hold = 1'b1; rd_ch = '0;
    for (int c = 0; c < NCH; c++) begin
      m_in[c] = '0; m_out[c] = '0; m_pend[c] = 1'b0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");

    // R6: strobe low, busy data and load_hold low
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      wr_ch = 2'(i); wr_data = 16'hFFFF - 16'(i * 4369); load_hold = 1'b0;
    end
    @(negedge clk);
    check_all("R6");

    // Sweep all channels, all modes, codes from 0 to 4095; ignored bits set to 1
    for (int ch = 0; ch < NCH; ch++) begin
      for (int pd = 0; pd < 4; pd++) begin
        for (int k = 0; k < 6; k++) begin
          int code;
          logic h;
          code = (k == 0) ? 0 : (k == 5) ? 4095 : (ch * 1031 + pd * 257 + k * 683) % 4096;
          h = (k % 2 == 0);
          wr(ch, {2'(pd), 12'(code), 2'b11}, h, h ? "R2" : "R3");
        end
      end
    end

    // R4: three held writes, fourth with load_hold low
    wr(0, {2'b01, 12'h111, 2'b00}, 1'b1, "R2");
    wr(1, {2'b10, 12'h222, 2'b00}, 1'b1, "R2");
    wr(2, {2'b11, 12'h333, 2'b01}, 1'b1, "R2");
    wr(3, {2'b00, 12'h444, 2'b10}, 1'b0, "R4");

    // R5: load event with no other new data
    wr(1, {2'b10, 12'h222, 2'b00}, 1'b0, "R5");
    // R5: mixed pending and stale channels
    wr(2, {2'b00, 12'hABC, 2'b00}, 1'b1, "R2");
    wr(0, {2'b00, 12'hFED, 2'b00}, 1'b0, "R5");

    // R8: mode staged, applied only at transfer
    wr(3, {2'b11, 12'h0F0, 2'b00}, 1'b1, "R8");
    @(negedge clk);
    check_all("R8");
    wr(0, {2'b01, 12'h00F, 2'b00}, 1'b0, "R8");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule